// File: doc/BRIEF.md
# Clock Output Gating Stage

This stage sits between a programmable-skew clock generator and the eight output pins of a clock driver. The outputs form four banks of two. For each bank it picks a source: the generated clock, or the reference clock itself when the loop is bypassed for test. It then enables or parks that bank. A global stop input parks every bank except the one that feeds the loop back. A polarity input selects which reference edge the outputs line up with. A three-level test input selects normal operation, bypass, or a mode in which each bank can be switched off through its own select pins.

Every enable change waits for the bank's source to sit at the bank's park level, so no pulse is ever cut short. The stop, polarity, test and reference inputs each cross into the fast clock domain through a two-flop synchronizer. When the synchronized test level changes, every bank is parked until the effective reference has risen twice, which spans at least one full period. Only then does the new mode take effect.

Top module: `out_gate_ctrl`

## Requirements
- R1: With `test_i` LOW (2'b00) and `stop_i` LOW, every output pair `q_o[2b+1:2b]` follows the generated clock `gen_clk_i[b]` of its bank b.
- R2: With `stop_i` HIGH and `test_i` LOW or HIGH, banks 0, 1 and 3 park LOW, and bank 2 (bits 5:4) keeps running.
- R3: When bank 3 is in its inverted setting (`sel_i[15:12]` = 4'b1010, both pins HIGH) and is disabled, it parks at the level of `pol_i`: HIGH when `pol_i` is 1 and LOW when `pol_i` is 0.
- R4: With `test_i` HIGH (2'b10), the outputs are driven from the effective reference, and `gen_clk_i` has no effect on them.
- R5: With `test_i` MID (2'b01) and `stop_i` HIGH, the generated clocks drive the outputs. A bank whose select nibble `sel_i[4b+3:4b]` reads 4'b0000 (both pins LOW) parks LOW. Bank 2 and every other bank keep running.
- R6: With `test_i` MID and `stop_i` LOW, the outputs are driven from the effective reference, as in R4. The code 2'b11 on a three-level input reads as MID.
- R7: `ref_loop_o` equals the reference when `pol_i` is 1 and its complement when `pol_i` is 0. In bypass, the outputs follow this effective reference.
- R8: An output enable changes only while the bank's source sits at its park level, so no output pulse is shortened.
- R9: After the synchronized test level changes, all banks park and stay parked for at least one full period of the effective reference before the new mode starts.
- R10: During reset every output is LOW and the mode is normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_i | input | 1 | Reference clock, sampled in the fast domain |
| gen_clk_i | input | 4 | Generated clock, one per bank |
| stop_i | input | 1 | Global stop; 1 parks all banks except bank 2 |
| pol_i | input | 1 | Edge select; 1 = rising edge, 0 = falling edge |
| test_i | input | 2 | Three-level test: 00 LOW, 01 MID, 10 HIGH, 11 MID |
| sel_i | input | 16 | Per-bank select, two three-level pins per bank |
| q_o | output | 8 | Output pins, two per bank |
| ref_loop_o | output | 1 | Polarity-adjusted reference for the phase detector |

## Verification
The bench builds the block with its default parameters: four banks of two outputs, bank 2 as the never-parked bank, bank 3 as the bank that can be inverted, two synchronizer stages, and two reference rises of hold. With these values one bench can reach both special banks alongside two plain banks, and the hold window after a test-level change stays short enough to measure as a single parked stretch on one output. Because the bench's reference and generated clocks run in phase, a switch between the two sources must be seamless. Any output run shorter than half a source period therefore shows a gating fault.

// File: rtl/ogate_pkg.sv
package ogate_pkg;
  typedef enum logic [1:0] {
    TRI_LOW  = 2'b00,
    TRI_MID  = 2'b01,
    TRI_HIGH = 2'b10
  } tri_t;

  localparam logic [3:0] SEL_LL = 4'b0000;
  localparam logic [3:0] SEL_HH = 4'b1010;

  // undriven pins float to MID; 2'b11 is read the same way
  function automatic tri_t norm_tri(input logic [1:0] v);
    return (v == 2'b11) ? TRI_MID : tri_t'(v);
  endfunction
endpackage

// File: rtl/ogate_sync.sv
module ogate_sync #(
  parameter int         W       = 1,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ogate_mode.sv
module ogate_mode
  import ogate_pkg::*;
#(
  parameter int HOLD_RISES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] test_i,
  input  logic       stop_i,
  input  logic       ref_eff_i,
  output logic       bypass_o,
  output logic       indiv_o,
  output logic       hold_o
);
  localparam int CW = $clog2(HOLD_RISES + 1);

  tri_t          mode_q;
  tri_t          test_n;
  logic          hold_q;
  logic          ref_q;
  logic [CW-1:0] rise_cnt_q;
  logic          ref_rise;

  assign test_n   = norm_tri(test_i);
  assign ref_rise = ref_eff_i & ~ref_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= TRI_LOW;
      hold_q     <= 1'b0;
      ref_q      <= 1'b0;
      rise_cnt_q <= '0;
    end else begin
      ref_q <= ref_eff_i;
      if (!hold_q) begin
        if (test_n != mode_q) begin
          hold_q     <= 1'b1;
          rise_cnt_q <= '0;
        end
      end else if (ref_rise) begin
        if (rise_cnt_q == CW'(HOLD_RISES - 1)) begin
          hold_q     <= 1'b0;
          mode_q     <= test_n;
          rise_cnt_q <= '0;
        end else begin
          rise_cnt_q <= rise_cnt_q + 1'b1;
        end
      end
    end
  end

  assign indiv_o  = (mode_q == TRI_MID) && stop_i;
  assign bypass_o = (mode_q != TRI_LOW) && !indiv_o;
  assign hold_o   = hold_q;

  AST_MODE_ONLY_IN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) !$stable(mode_q) |-> $past(hold_q)); // R9
  AST_HOLD_MIN_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni) $fell(hold_q) |-> $past(hold_q, 2)); // R9
endmodule

// File: rtl/ogate_bank.sv
module ogate_bank
  import ogate_pkg::*;
#(
  parameter int PAIR   = 2,
  parameter bit IS_FB  = 1'b0,
  parameter bit INV_OK = 1'b0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            gen_i,
  input  logic            ref_eff_i,
  input  logic            bypass_i,
  input  logic            hold_i,
  input  logic            stop_i,
  input  logic            indiv_i,
  input  logic            pol_i,
  input  logic [3:0]      sel_i,
  output logic [PAIR-1:0] q_o,
  output logic            en_o
);
  logic inv, park, dis_req, src_d, src_q, en_q;

  assign inv     = INV_OK & (sel_i == SEL_HH);
  assign park    = inv & pol_i;
  // the loop-feedback bank only yields to a mode-change hold
  assign dis_req = hold_i | (~IS_FB & (indiv_i ? (sel_i == SEL_LL) : stop_i));
  assign src_d   = bypass_i ? (ref_eff_i ^ inv) : gen_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      src_q <= src_d;
      if (src_q == park) en_q <= ~dis_req;
    end
  end

  assign q_o  = {PAIR{en_q ? src_q : park}};
  assign en_o = en_q;

  AST_GATE_ON_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni) !$stable(en_q) |-> $past(src_q == park)); // R8
endmodule

// File: rtl/out_gate_ctrl.sv
module out_gate_ctrl
  import ogate_pkg::*;
#(
  parameter int NBANK       = 4,
  parameter int PAIR        = 2,
  parameter int FB_BANK     = 2,
  parameter int INV_BANK    = 3,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_RISES  = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ref_i,
  input  logic [NBANK-1:0]      gen_clk_i,
  input  logic                  stop_i,
  input  logic                  pol_i,
  input  logic [1:0]            test_i,
  input  logic [4*NBANK-1:0]    sel_i,
  output logic [NBANK*PAIR-1:0] q_o,
  output logic                  ref_loop_o
);
  logic [1:0]       test_s;
  logic             stop_s, ref_s, pol_s, ref_eff;
  logic             bypass, indiv, hold;
  logic [NBANK-1:0] en_w;

  ogate_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0000)) u_sync_ctl (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({test_i, stop_i, ref_i}),
    .q_o   ({test_s, stop_s, ref_s})
  );

  ogate_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_pol (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pol_i),
    .q_o   (pol_s)
  );

  assign ref_eff    = pol_s ? ref_s : ~ref_s;
  assign ref_loop_o = ref_eff;

  ogate_mode #(.HOLD_RISES(HOLD_RISES)) u_mode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .test_i   (test_s),
    .stop_i   (stop_s),
    .ref_eff_i(ref_eff),
    .bypass_o (bypass),
    .indiv_o  (indiv),
    .hold_o   (hold)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    ogate_bank #(
      .PAIR  (PAIR),
      .IS_FB (b == FB_BANK),
      .INV_OK(b == INV_BANK)
    ) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .gen_i    (gen_clk_i[b]),
      .ref_eff_i(ref_eff),
      .bypass_i (bypass),
      .hold_i   (hold),
      .stop_i   (stop_s),
      .indiv_i  (indiv),
      .pol_i    (pol_s),
      .sel_i    (sel_i[4*b +: 4]),
      .q_o      (q_o[b*PAIR +: PAIR]),
      .en_o     (en_w[b])
    );
  end

  AST_FB_KEEPS_RUNNING: assert property (@(posedge clk_i) disable iff (!rst_ni) (!hold && en_w[FB_BANK]) |=> en_w[FB_BANK]); // R2
  AST_LOOP_POLARITY: assert property (@(posedge clk_i) disable iff (!rst_ni) ($stable(pol_s) && !$stable(ref_s)) |-> !$stable(ref_loop_o)); // R7
  AST_RESET_PARKED: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(rst_ni) |-> (q_o == '0)); // R10
endmodule

// File: tb/tb_out_gate_ctrl.sv
module tb_out_gate_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ref_i, stop_i, pol_i;
  logic [3:0]  gen_clk_i;
  logic [1:0]  test_i;
  logic [15:0] sel_i;
  logic [7:0]  q_o;
  logic        ref_loop_o;

  always #10 clk = ~clk;

  out_gate_ctrl dut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .ref_i     (ref_i),
    .gen_clk_i (gen_clk_i),
    .stop_i    (stop_i),
    .pol_i     (pol_i),
    .test_i    (test_i),
    .sel_i     (sel_i),
    .q_o       (q_o),
    .ref_loop_o(ref_loop_o)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit arm = 0;
  bit gen_run = 1, inv3 = 0, ref_run = 1;
  logic ref_lvl = 1'b0;
  int cyc = 0;

  // sources: period 8; reference leads by the two synchronizer cycles
  always @(negedge clk) begin : drv
    logic bg, br;
    cyc++;
    bg = (cyc % 8) < 4;
    br = ((cyc + 2) % 8) < 4;
    gen_clk_i <= gen_run ? {inv3 ? ~bg : bg, bg, bg, bg} : 4'b0000;
    ref_i     <= ref_run ? br : ref_lvl;
  end

  typedef struct {
    int         len;
    logic [7:0] run;
    logic [7:0] lvl;
    bit         chk_lp;
    logic       lp;
    bit         hold;
    string      tag;
  } item_t;

  item_t sb[$];
  bit busy = 0;

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_wait(item_t it);
    sb.push_back(it);
    @(negedge clk);
    wait (!busy && sb.size() == 0);
  endtask

  task automatic expect_win(string tag, logic [7:0] run, logic [7:0] lvl, bit chk_lp = 0, logic lp = 1'b0);
    item_t it;
    it.len = 16; it.run = run; it.lvl = lvl; it.chk_lp = chk_lp; it.lp = lp; it.hold = 0; it.tag = tag;
    push_wait(it);
  endtask

  task automatic expect_hold(string tag);
    item_t it;
    it.len = 40; it.run = '0; it.lvl = '0; it.chk_lp = 0; it.lp = 1'b0; it.hold = 1; it.tag = tag;
    push_wait(it);
  endtask

  initial begin
    forever begin : mon
      item_t it;
      logic [7:0] prev, tog;
      int lowrun, maxlow;
      bit lpbad;
      wait (sb.size() != 0);
      it = sb.pop_front();
      busy = 1;
      @(negedge clk);
      prev = q_o; tog = '0;
      lowrun = (q_o[0] == 1'b0) ? 1 : 0;
      maxlow = lowrun;
      lpbad = it.chk_lp && (ref_loop_o !== it.lp);
      for (int i = 1; i < it.len; i++) begin
        @(negedge clk);
        tog |= q_o ^ prev;
        prev = q_o;
        if (q_o[0] == 1'b0) lowrun++; else lowrun = 0;
        if (lowrun > maxlow) maxlow = lowrun;
        if (it.chk_lp && ref_loop_o !== it.lp) lpbad = 1;
      end
      checks++;
      if (it.hold) begin
        if (maxlow < 8) begin
          failures++;
          $display("FAIL %s: parked run=%0d expected >=8", it.tag, maxlow);
        end
      end else if (tog !== it.run || ((prev & ~it.run) !== (it.lvl & ~it.run)) || lpbad) begin
        failures++;
        $display("FAIL %s: toggled=%b level=%b loop=%b expected toggled=%b level=%b loop=%b",
                 it.tag, tog, prev, ref_loop_o, it.run, it.lvl, it.lp);
      end
      busy = 0;
    end
  end

  // R8: no output run shorter than half a source period while armed
  int rl [8];
  logic [7:0] pv = '0;
  always @(negedge clk) begin
    for (int i = 0; i < 8; i++) begin
      if (!arm) rl[i] = 0;
      else if (q_o[i] != pv[i]) begin
        if (rl[i] > 0 && rl[i] < 4) begin
          failures++;
          $display("FAIL R8: output %0d run=%0d expected >=4", i, rl[i]);
        end
        rl[i] = 1;
      end else if (rl[i] > 0) rl[i]++;
    end
    pv = q_o;
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end

  initial begin
    stop_i = 0; pol_i = 1; test_i = 2'b00; sel_i = 16'h5555;
    settle(3);
    checks++;
    if (q_o !== 8'h00) begin
      failures++;
      $display("FAIL R10: q=%b expected %b", q_o, 8'h00);
    end
    rst_ni = 1'b1;
    settle(24);
    arm = 1;
    expect_win("R1 normal run", 8'hFF, 8'h00);

    stop_i = 1; settle(24);
    expect_win("R2 stop parks all but bank 2", 8'h30, 8'h00);
    stop_i = 0; settle(24);
    expect_win("R1 resume after stop", 8'hFF, 8'h00);

    arm = 0; sel_i[15:12] = 4'b1010; inv3 = 1; settle(16);
    arm = 1; stop_i = 1; settle(24);
    expect_win("R3 inverted bank parks high", 8'h30, 8'hC0);
    arm = 0; pol_i = 0; settle(24);
    expect_win("R3 inverted bank parks low", 8'h30, 8'h00);
    pol_i = 1; stop_i = 0; sel_i[15:12] = 4'b0101; inv3 = 0; settle(32);
    arm = 1; settle(8);

    test_i = 2'b10;
    expect_hold("R9 hold on test change");
    settle(24);
    arm = 0; gen_run = 0; settle(24);
    arm = 1;
    expect_win("R4 bypass ignores generator", 8'hFF, 8'h00);

    arm = 0; ref_run = 0; ref_lvl = 1'b1; settle(24);
    expect_win("R7 rising-edge polarity", 8'h00, 8'hFF, 1, 1'b1);
    pol_i = 0; settle(24);
    expect_win("R7 falling-edge polarity", 8'h00, 8'h00, 1, 1'b0);
    pol_i = 1; ref_run = 1; gen_run = 1; settle(24);
    arm = 1;

    test_i = 2'b01; settle(48);
    sel_i[3:0] = 4'b0000; sel_i[11:8] = 4'b0000; stop_i = 1; settle(24);
    expect_win("R5 LL bank parks, bank 2 runs", 8'hFC, 8'h00);
    arm = 0; ref_run = 0; ref_lvl = 1'b0; settle(24);
    expect_win("R5 generator drives in individual mode", 8'hFC, 8'h00);
    stop_i = 0; settle(24);
    expect_win("R6 MID bypass static ref", 8'h00, 8'h00);
    gen_run = 0; ref_run = 1; settle(24);
    expect_win("R6 MID bypass follows ref", 8'hFF, 8'h00);

    gen_run = 1; settle(16);
    arm = 1; sel_i = 16'h5555; test_i = 2'b00; settle(48);
    expect_win("R1 back to normal", 8'hFF, 8'h00);

    checks++; // R8 run-length monitor verdict
    done = 1;
    finish_run();
  end
endmodule